// File: doc/BRIEF.md
# Byte-Loaded ARINC 429 Word Transmitter

This block turns four bytes written over an 8-bit parallel port into one 32-bit ARINC 429 word. It sends the word one bit per transmit clock and follows each word with a fixed four-bit-time null gap. The host writes the first byte with the address line high, which restarts the byte sequence, and writes the other three bytes with it low. A holding buffer takes the next word while the current one shifts out, so a steady stream of words runs at one word per 36 clocks. The buffer passes to the shifter in the last gap slot. If that slot has already gone by, the transfer happens one clock after the buffer fills.

Bit 32 can carry an odd-parity bit in place of the top data bit. The serial stream appears in two forms. One is a pair of return-to-zero strobes, one for ones and one for zeros, for an external line driver. The other is a level-coded data line with an active-low sync pulse in the eighth bit. The whole block runs on the transmit clock. The write strobe, the address line and the parity enable are brought in through two-flop synchronizers.

Top module: `arinc_byte_tx`

## Requirements
- R1: Byte n (n = 1..4), bit k (k = 0..7) goes out as word bit 8(n-1)+k+1, one bit per clock, bit 1 first. Bit 0 of the first byte is the first bit on the line.
- R2: When the next word is already buffered, exactly 4 null bit times separate the last bit of one word from the first bit of the next, giving a 36-clock period.
- R3: A write with the address line high stores the first byte and restarts the byte count, even in the middle of a sequence. The next three writes with the address line low store bytes 2, 3 and 4. A write with the address line low is ignored if no address-high write has come since reset or since the last completed word.
- R4: A byte is captured only after the rising edge that ends a low pulse on the active-low write strobe. While the strobe is held low, nothing is stored.
- R5: The ready output is high while the holding buffer is empty and falls after the fourth byte is written. Any write while ready is low is ignored, and the buffered word keeps its contents.
- R6: The buffer moves to the shifter at the end of the fourth gap bit. If the line is idle, it moves one clock after the buffer fills, so ready is low for exactly one clock. Ready is high again in the clock that sends bit 1.
- R7: With parity enabled at transfer, bit 32 is set so that the word has an odd number of ones. With parity disabled, bit 32 is bit 7 of byte 4.
- R8: Reset is synchronous and active low. It clears the buffer and the sequencing state, aborts a word that is being sent, sets ready high and holds the line in null until a complete word has been loaded.
- R9: data_one_o is high during the high half of the clock for each one bit, and data_zero_o is high during the high half for each zero bit. Both are low in the low half of every clock and for the whole gap, and they are never high together.
- R10: ser_data_o carries the bit value for the full bit period and is low during the gap.
- R11: sync_n_o is low only during the low half of the clock in the 8th bit of each word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock; one bit per period |
| rst_n | input | 1 | Synchronous active-low reset |
| data_i | input | 8 | Parallel byte bus |
| wr_n | input | 1 | Active-low write strobe; capture follows its rising edge |
| a0_i | input | 1 | Byte address: high for the first byte, low for bytes 2 to 4 |
| par_en_i | input | 1 | High selects odd parity in bit 32 |
| ready_o | output | 1 | High while the holding buffer is empty |
| data_one_o | output | 1 | Return-to-zero strobe for one bits |
| data_zero_o | output | 1 | Return-to-zero strobe for zero bits |
| ser_data_o | output | 1 | Level-coded serial data, low during the gap |
| sync_n_o | output | 1 | Active-low pulse in the low half of bit 8 |

## Verification
The bench streams walking-one words and arithmetic patterns back to back, with parity off and then on. A wrong byte or bit order shows up as a displaced bit, and an off-by-one gap counter shows up as a 3- or 5-clock gap. It checks that an idle line holds ready low for exactly one clock, so a design that waits for a full gap slot is caught. It writes stray bytes while the buffer is full and address-low bytes after reset. A design that accepts either would corrupt the buffered word or start a word of its own. It also holds the strobe low to catch capture on the falling edge, restarts a sequence with a second address-high write, and resets in the middle of a word to check that nothing more is sent.

// File: rtl/arinc_tx_pkg.sv
// Shared defaults and types for the byte-loaded ARINC word transmitter.
package arinc_tx_pkg;
    localparam int DEF_BYTE_W    = 8;
    localparam int DEF_NUM_BYTES = 4;
    localparam int DEF_GAP_BITS  = 4;
    localparam int DEF_SYNC_BIT  = 8;

    // Holding buffer state: empty and not armed, partly filled, full.
    typedef enum logic [1:0] {
        LD_EMPTY = 2'd0,
        LD_FILL  = 2'd1,
        LD_FULL  = 2'd2
    } ld_state_e;
endpackage

// File: rtl/atx_loader.sv
// Byte loader: synchronizes the write strobe, the address line and the parity
// enable into the transmit clock domain and assembles NUM_BYTES bytes into the
// holding buffer. Assumes data_i stays stable from the strobe's rising edge
// until at least three clock edges later, and NUM_BYTES >= 2.
module atx_loader
    import arinc_tx_pkg::*;
#(
    parameter int BYTE_W    = 8,
    parameter int NUM_BYTES = 4,
    localparam int WORD_W   = BYTE_W * NUM_BYTES,
    localparam int CNT_W    = $clog2(NUM_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] data_i,
    input  logic              wr_n_i,
    input  logic              a0_i,
    input  logic              par_en_i,
    input  logic              take_i,
    output logic [WORD_W-1:0] buf_o,
    output logic              full_o,
    output logic              par_en_o
);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(NUM_BYTES - 1);

    logic [2:0]        wr_q;
    logic [1:0]        a0_q;
    logic [1:0]        par_q;
    logic              wr_edge;
    ld_state_e         state_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [WORD_W-1:0] hold_q;

    // Two-flop synchronizers plus one extra strobe stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q  <= '1;
            a0_q  <= '0;
            par_q <= '0;
        end else begin
            wr_q  <= {wr_q[1:0], wr_n_i};
            a0_q  <= {a0_q[0], a0_i};
            par_q <= {par_q[0], par_en_i};
        end
    end

    assign wr_edge = wr_q[1] & ~wr_q[2];

    // Byte sequencing and buffer fill; writes are ignored while the buffer is full.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LD_EMPTY;
            cnt_q   <= '0;
            hold_q  <= '0;
        end else if (take_i) begin
            state_q <= LD_EMPTY;
        end else if (wr_edge && state_q != LD_FULL) begin
            if (a0_q[1]) begin
                hold_q[BYTE_W-1:0] <= data_i;
                cnt_q              <= CNT_W'(1);
                state_q            <= LD_FILL;
            end else if (state_q == LD_FILL) begin
                hold_q[cnt_q*BYTE_W +: BYTE_W] <= data_i;
                cnt_q <= (cnt_q == LAST_CNT) ? '0 : cnt_q + 1'b1;
                if (cnt_q == LAST_CNT) state_q <= LD_FULL;
            end
        end
    end

    assign buf_o    = hold_q;
    assign full_o   = (state_q == LD_FULL);
    assign par_en_o = par_q[1];

    // R5: a full buffer keeps its contents until the shifter takes it.
    assert_hold_when_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (full_o && !take_i) |=> (full_o && $stable(hold_q)));

    // R4: the buffer only becomes full after a detected strobe edge.
    assert_full_after_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(full_o) |-> $past(wr_edge));
endmodule

// File: rtl/atx_shifter.sv
// Word sequencer and shift register: a single position counter walks through
// WORD_W data slots and GAP_BITS gap slots and rests in the last gap slot while
// idle. A full buffer is taken only in that last slot. The parity bit is
// inserted at transfer time.
module atx_shifter #(
    parameter int WORD_W   = 32,
    parameter int GAP_BITS = 4,
    localparam int PERIOD  = WORD_W + GAP_BITS,
    localparam int POS_W   = $clog2(PERIOD)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] buf_i,
    input  logic              full_i,
    input  logic              par_en_i,
    output logic              take_o,
    output logic              bit_o,
    output logic              in_word_o,
    output logic [POS_W-1:0]  pos_o
);
    localparam logic [POS_W-1:0] LAST_POS = POS_W'(PERIOD - 1);
    localparam logic [POS_W-1:0] WORD_POS = POS_W'(WORD_W);

    logic [POS_W-1:0]  pos_q;
    logic [WORD_W-1:0] sh_q;
    logic [WORD_W-1:0] word_in;

    // Replace the top bit by odd parity over the rest when enabled.
    always_comb begin
        word_in = buf_i;
        if (par_en_i) word_in[WORD_W-1] = ~^buf_i[WORD_W-2:0];
    end

    assign take_o = full_i && (pos_q == LAST_POS);

    // Advance the slot counter, load on transfer, shift out least significant bit first.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q <= LAST_POS;
            sh_q  <= '0;
        end else if (take_o) begin
            pos_q <= '0;
            sh_q  <= word_in;
        end else if (pos_q != LAST_POS) begin
            pos_q <= pos_q + 1'b1;
            sh_q  <= sh_q >> 1;
        end
    end

    assign bit_o     = sh_q[0];
    assign in_word_o = (pos_q < WORD_POS);
    assign pos_o     = pos_q;

    // R6: a word starts only out of the last gap slot with a full buffer.
    assert_start_from_slot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_q == '0) |-> ($past(pos_q) == LAST_POS && $past(full_i)));

    // R7: a word loaded with parity enabled holds an odd number of ones.
    assert_odd_word_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_q == '0 && $past(par_en_i)) |-> (^sh_q));
endmodule

// File: rtl/atx_encode.sv
// Output encoder: return-to-zero one and zero strobes gated by the clock's high
// half, level-coded serial data, and the active-low sync in the low half of the
// sync bit. Assumes a free-running transmit clock with a near 50% duty cycle.
module atx_encode #(
    parameter int POS_W    = 6,
    parameter int SYNC_BIT = 8
) (
    input  logic             clk,
    input  logic             bit_i,
    input  logic             in_word_i,
    input  logic [POS_W-1:0] pos_i,
    output logic             data_one_o,
    output logic             data_zero_o,
    output logic             ser_data_o,
    output logic             sync_n_o
);
    localparam logic [POS_W-1:0] SYNC_POS = POS_W'(SYNC_BIT - 1);

    // Combinational encoding of the current slot.
    always_comb begin
        data_one_o  = in_word_i &  bit_i & clk;
        data_zero_o = in_word_i & ~bit_i & clk;
        ser_data_o  = in_word_i &  bit_i;
        sync_n_o    = ~(in_word_i & (pos_i == SYNC_POS) & ~clk);
    end
endmodule

// File: rtl/arinc_byte_tx.sv
// Top level: byte loader, word shifter and output encoder on one transmit clock.
// Assumes the host writes only while ready_o is high and keeps par_en_i stable
// while a word is waiting for transfer.
module arinc_byte_tx
    import arinc_tx_pkg::*;
#(
    parameter int BYTE_W    = DEF_BYTE_W,
    parameter int NUM_BYTES = DEF_NUM_BYTES,
    parameter int GAP_BITS  = DEF_GAP_BITS,
    parameter int SYNC_BIT  = DEF_SYNC_BIT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] data_i,
    input  logic              wr_n,
    input  logic              a0_i,
    input  logic              par_en_i,
    output logic              ready_o,
    output logic              data_one_o,
    output logic              data_zero_o,
    output logic              ser_data_o,
    output logic              sync_n_o
);
    localparam int WORD_W = BYTE_W * NUM_BYTES;
    localparam int PERIOD = WORD_W + GAP_BITS;
    localparam int POS_W  = $clog2(PERIOD);

    logic [WORD_W-1:0] buf_w;
    logic              full_w;
    logic              par_w;
    logic              take_w;
    logic              bit_w;
    logic              in_word_w;
    logic [POS_W-1:0]  pos_w;

    atx_loader #(.BYTE_W(BYTE_W), .NUM_BYTES(NUM_BYTES)) u_loader (
        .clk      (clk),
        .rst_n    (rst_n),
        .data_i   (data_i),
        .wr_n_i   (wr_n),
        .a0_i     (a0_i),
        .par_en_i (par_en_i),
        .take_i   (take_w),
        .buf_o    (buf_w),
        .full_o   (full_w),
        .par_en_o (par_w)
    );

    atx_shifter #(.WORD_W(WORD_W), .GAP_BITS(GAP_BITS)) u_shifter (
        .clk       (clk),
        .rst_n     (rst_n),
        .buf_i     (buf_w),
        .full_i    (full_w),
        .par_en_i  (par_w),
        .take_o    (take_w),
        .bit_o     (bit_w),
        .in_word_o (in_word_w),
        .pos_o     (pos_w)
    );

    atx_encode #(.POS_W(POS_W), .SYNC_BIT(SYNC_BIT)) u_encode (
        .clk         (clk),
        .bit_i       (bit_w),
        .in_word_i   (in_word_w),
        .pos_i       (pos_w),
        .data_one_o  (data_one_o),
        .data_zero_o (data_zero_o),
        .ser_data_o  (ser_data_o),
        .sync_n_o    (sync_n_o)
    );

    assign ready_o = ~full_w;

    // R8: ready is high in the first cycle after reset.
    assert_ready_after_reset_R8: assert property (@(posedge clk)
        (rst_n && !$past(rst_n)) |-> ready_o);
endmodule

// File: tb/arinc_byte_tx_tb.sv
module arinc_byte_tx_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] din = 8'h00;
    logic       wr_n = 1'b1;
    logic       a0 = 1'b0;
    logic       par = 1'b0;
    logic       rdy, d_one, d_zero, sdat, sync_n;

    arinc_byte_tx u_dut (
        .clk(clk), .rst_n(rst_n), .data_i(din), .wr_n(wr_n), .a0_i(a0),
        .par_en_i(par), .ready_o(rdy), .data_one_o(d_one), .data_zero_o(d_zero),
        .ser_data_o(sdat), .sync_n_o(sync_n)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    logic [31:0] exp_w_q[$];
    bit          exp_idle_q[$];

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Monitor state.
    int          bitcnt = 0, gapcnt = 99, lowrun = 0, gap_before = 0, run_before = 0;
    int          bits_seen = 0;
    bit          rdy_first = 1'b0, bit_now = 1'b0;
    bit          rz_err = 1'b0, ser_err = 1'b0, sync_err = 1'b0;
    logic [31:0] cur = '0;

    initial begin
        forever begin
            @(posedge clk); #2;
            if (!rst_n) begin
                bitcnt = 0; gapcnt = 99; lowrun = 0; bit_now = 1'b0;
                rz_err = 1'b0; ser_err = 1'b0; sync_err = 1'b0;
            end else begin
                bit_now = d_one | d_zero;
                if (d_one && d_zero) rz_err = 1'b1;
                if (sync_n !== 1'b1) sync_err = 1'b1;
                if (bit_now) begin
                    if (sdat !== d_one) ser_err = 1'b1;
                    if (bitcnt == 0) begin
                        gap_before = gapcnt; run_before = lowrun; rdy_first = rdy;
                    end
                    cur[bitcnt] = d_one;
                    bitcnt++; gapcnt = 0; bits_seen++;
                end else begin
                    if (sdat !== 1'b0) ser_err = 1'b1;
                    if (gapcnt < 99) gapcnt++;
                end
                lowrun = rdy ? 0 : lowrun + 1;
            end
            #5;
            if (rst_n) begin
                if (d_one || d_zero) rz_err = 1'b1;
                if (sync_n !== !(bit_now && bitcnt == 8)) sync_err = 1'b1;
                if (bit_now && bitcnt == 32) begin
                    if (exp_w_q.size() == 0) begin
                        check(1'b0, "R1", "unexpected word", cur, 32'h0);
                    end else begin
                        logic [31:0] ew;
                        bit          eidle;
                        ew = exp_w_q.pop_front();
                        eidle = exp_idle_q.pop_front();
                        check(cur == ew, "R1", "word bits (R7 parity included)", cur, ew);
                        if (eidle)
                            check(run_before == 1, "R6", "idle ready-low clocks", run_before, 1);
                        else begin
                            check(gap_before == 4, "R2", "gap clocks", gap_before, 4);
                            check(run_before >= 1, "R6", "ready low before slot 4 transfer", run_before, 1);
                        end
                        check(rdy_first == 1'b1, "R6", "ready high in bit 1", rdy_first, 1);
                    end
                    check(!rz_err, "R9", "RZ strobe phase", rz_err, 0);
                    check(!ser_err, "R10", "serial level", ser_err, 0);
                    check(!sync_err, "R11", "sync pulse", sync_err, 0);
                    rz_err = 1'b0; ser_err = 1'b0; sync_err = 1'b0;
                    bitcnt = 0;
                end
            end
        end
    end

    task automatic wr_byte(input logic [7:0] d, input logic a);
        @(negedge clk);
        din = d; a0 = a; wr_n = 1'b0;
        repeat (2) @(negedge clk);
        wr_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic wait_ready();
        @(negedge clk);
        while (rdy !== 1'b1) @(negedge clk);
    endtask

    function automatic logic [31:0] expect_word(input logic [31:0] w, input logic p);
        return p ? {~^w[30:0], w[30:0]} : w;
    endfunction

    task automatic send_word(input logic [31:0] w, input bit idle);
        wait_ready();
        wr_byte(w[7:0], 1'b1);
        wr_byte(w[15:8], 1'b0);
        wr_byte(w[23:16], 1'b0);
        wr_byte(w[31:24], 1'b0);
        exp_w_q.push_back(expect_word(w, par));
        exp_idle_q.push_back(idle);
    endtask

    task automatic drain();
        while (exp_w_q.size() != 0) @(negedge clk);
        repeat (10) @(negedge clk);
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "R1", "watchdog expired", 0, 1);
        summary();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        bits_seen = 0;
        repeat (40) @(negedge clk);
        // R8: after reset, ready high and the line sends a continuous null
        check(rdy === 1'b1, "R8", "ready after reset", rdy, 1);
        check(bits_seen == 0, "R8", "no bits after reset", bits_seen, 0);
        check(sync_n === 1'b1 && sdat === 1'b0, "R8", "idle outputs", {sync_n, sdat}, 2'b10);

        // R3: address-low writes before any address-high write are ignored
        for (int i = 0; i < 4; i++) wr_byte(8'h5A, 1'b0);
        repeat (80) @(negedge clk);
        check(rdy === 1'b1, "R3", "ready after stray low-address writes", rdy, 1);
        check(bits_seen == 0, "R3", "no word from stray writes", bits_seen, 0);

        // R1, R2: walking ones back to back, parity off
        send_word(32'h0000_0000, 1'b1);
        for (int i = 0; i < 32; i++) begin
            send_word(32'h1 << i, 1'b0);
            if (i == 5) begin
                // R5: a write while the buffer is full is ignored
                wr_byte(8'hAA, 1'b1);
                check(rdy === 1'b0, "R5", "ready stays low after ignored write", rdy, 0);
            end
        end
        send_word(32'hFFFF_FFFF, 1'b0);
        drain();

        // R7: parity on, arithmetic patterns
        @(negedge clk) par = 1'b1;
        repeat (5) @(negedge clk);
        for (int i = 0; i < 40; i++)
            send_word((i * 32'h9E37_79B1) ^ (i << 3), i == 0);
        drain();

        // R3: a second address-high write restarts the sequence
        wr_byte(8'h11, 1'b1);
        wr_byte(8'h22, 1'b0);
        send_word(32'hC3A5_0F1E, 1'b1);
        drain();

        // R4: no capture while the strobe is held low
        @(negedge clk) par = 1'b0;
        repeat (5) @(negedge clk);
        wr_byte(8'h3C, 1'b1);
        wr_byte(8'h96, 1'b0);
        wr_byte(8'h0F, 1'b0);
        @(negedge clk);
        din = 8'hE1; a0 = 1'b0; wr_n = 1'b0;
        repeat (8) @(negedge clk);
        check(rdy === 1'b1, "R4", "ready while strobe held low", rdy, 1);
        wr_n = 1'b1;
        exp_w_q.push_back(32'hE10F963C);
        exp_idle_q.push_back(1'b1);
        repeat (4) @(negedge clk);
        drain();

        // R8: reset in the middle of a word aborts it
        send_word(32'h1234_5678, 1'b1);
        while (bits_seen < 10) @(negedge clk);
        rst_n = 1'b0;
        exp_w_q.delete();
        exp_idle_q.delete();
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        bits_seen = 0;
        repeat (60) @(negedge clk);
        check(rdy === 1'b1, "R8", "ready after mid-word reset", rdy, 1);
        check(bits_seen == 0, "R8", "no bits after mid-word reset", bits_seen, 0);

        send_word(32'h8000_0001, 1'b1);
        drain();
        summary();
    end
endmodule